// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software reaches it through a simple synchronous register bus with a byte address, a write strobe, write data and combinational read data. Each pin has an output value, a direction bit, and a readable synchronized pad level. When a pin is an input, its data bit reads back the pin level.

Each pin also has its own interrupt detector. The trigger is picked by a 2-bit mode field: low level, high level, rising edge or falling edge. A per-pin any-edge override makes the pin trigger on both edges. Detected events set sticky status bits, and software clears them by writing 1. A per-pin mask gates these bits into one combined interrupt line.

The pad inputs are asynchronous, so they pass through a two-flop synchronizer before any use. Pad multiplexing, electrical pad settings and the downstream interrupt controller are handled elsewhere.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register (data 0x00, direction 0x04, mode-low 0x0C, mode-high 0x10, mask 0x14, status 0x18, any-edge 0x1C) reads zero. `pad_oe` is all zero and `irq` is low.
- R2: A direction bit of 1 drives `pad_oe` high for that pin, and `pad_out` carries the matching data-register bit (1 high, 0 low). A direction bit of 0 keeps `pad_oe` low.
- R3: Reading the data register (0x00) returns the data-register bit for output pins and the synchronized pin level for input pins.
- R4: The level register (0x08) returns the pad level of every pin, whatever its direction, two clock edges after the pad changes. Writes to it have no effect.
- R5: Pin n's trigger mode is the 2-bit field at bit 2*(n mod 16). For pins 0–15 it is in register 0x0C, and for pins 16–31 it is in register 0x10. The encoding is 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R6: A status bit (0x18) is set on the clock edge after its pin's trigger condition is seen on the synchronized level. A pad edge therefore shows in status three edges after it is applied.
- R7: When a pin's bit in the any-edge register (0x1C) is 1, that pin triggers on both rising and falling edges, whatever its mode field holds.
- R8: A status bit stays set until software writes 1 to it at 0x18. Writing 0 leaves it unchanged.
- R9: A mask bit (0x14) of 1 lets that pin's status reach `irq`. A mask bit of 0 blocks it.
- R10: `irq` is the OR over all pins of status AND mask. Status bits are still set for masked pins.
- R11: If a trigger event and a write-1 clear hit the same status bit in the same cycle, the bit stays set. In a level mode, the bit is set again on every cycle the level persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output values toward the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A software clear of a status bit and a new trigger on the same pin can land on the same clock edge. The bench provokes this in two ways. First, it holds a pin at its high level in high-level mode and writes the clear. Second, it times a rising pad edge so that the write-1 strobe is taken on the very edge where the detector fires. In both cases the bit must read back as set, and a later clear with no event pending must empty it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_DATA    = 3'd0,
    SEL_DIR     = 3'd1,
    SEL_LEVEL   = 3'd2,
    SEL_MODE_LO = 3'd3,
    SEL_MODE_HI = 3'd4,
    SEL_MASK    = 3'd5,
    SEL_STAT    = 3'd6,
    SEL_ANYEDGE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] mode,
  input  logic       any_edge,
  output logic       evt
);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  assign prev_d = lvl;
  assign rise   = lvl & ~prev_q;
  assign fall   = ~lvl & prev_q;

  always_comb begin
    if (any_edge) begin
      evt = rise | fall;
    end else begin
      unique case (trig_mode_e'(mode))
        TRIG_LOW:  evt = ~lvl;
        TRIG_HIGH: evt = lvl;
        TRIG_RISE: evt = rise;
        TRIG_FALL: evt = fall;
        default:   evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  AST_RISE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_RISE && $rose(lvl)) |-> evt); // R5

  AST_ANYEDGE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (any_edge && $fell(lvl)) |-> evt); // R7

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  lvl,
  input  logic [N-1:0]  evt,
  output logic [N-1:0]  rdata,
  output logic [N-1:0]  dout,
  output logic [N-1:0]  dir,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  status,
  output logic [N-1:0]  any_edge,
  output logic [2*N-1:0] modes
);

  localparam int HALF = N / 2;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[4:2]);

  logic [N-1:0] dout_q, dout_d;
  logic [N-1:0] dir_q,  dir_d;
  logic [N-1:0] mlo_q,  mlo_d;
  logic [N-1:0] mhi_q,  mhi_d;
  logic [N-1:0] mask_q, mask_d;
  logic [N-1:0] stat_q, stat_d;
  logic [N-1:0] any_q,  any_d;
  logic [N-1:0] clr_bits;

  always_comb begin
    dout_d   = dout_q;
    dir_d    = dir_q;
    mlo_d    = mlo_q;
    mhi_d    = mhi_q;
    mask_d   = mask_q;
    any_d    = any_q;
    clr_bits = '0;
    if (we) begin
      unique case (sel)
        SEL_DATA:    dout_d   = wdata;
        SEL_DIR:     dir_d    = wdata;
        SEL_MODE_LO: mlo_d    = wdata;
        SEL_MODE_HI: mhi_d    = wdata;
        SEL_MASK:    mask_d   = wdata;
        SEL_STAT:    clr_bits = wdata;
        SEL_ANYEDGE: any_d    = wdata;
        default:     ;
      endcase
    end
    stat_d = (stat_q & ~clr_bits) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
      any_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      mlo_q  <= mlo_d;
      mhi_q  <= mhi_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      any_q  <= any_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:    rdata = (dout_q & dir_q) | (lvl & ~dir_q);
      SEL_DIR:     rdata = dir_q;
      SEL_LEVEL:   rdata = lvl;
      SEL_MODE_LO: rdata = mlo_q;
      SEL_MODE_HI: rdata = mhi_q;
      SEL_MASK:    rdata = mask_q;
      SEL_STAT:    rdata = stat_q;
      SEL_ANYEDGE: rdata = any_q;
      default:     rdata = '0;
    endcase
  end

  assign dout     = dout_q;
  assign dir      = dir_q;
  assign mask     = mask_q;
  assign status   = stat_q;
  assign any_edge = any_q;
  assign modes    = {mhi_q[2*HALF-1:0], mlo_q[2*HALF-1:0]};

  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == SEL_STAT) |=> ((status & $past(status)) == $past(status))); // R8

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_DIR) |=> (dir == $past(wdata))); // R2

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic          irq
);

  localparam int SYNC_STAGES = 2;

  logic [N-1:0]   lvl;
  logic [N-1:0]   evt;
  logic [N-1:0]   dout, dir, mask, status, any_edge;
  logic [2*N-1:0] modes;

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (lvl)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    gpio_trig_det u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl[p]),
      .mode     (modes[2*p +: 2]),
      .any_edge (any_edge[p]),
      .evt      (evt[p])
    );
  end

  gpio_regs #(.N(N), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .lvl      (lvl),
    .evt      (evt),
    .rdata    (bus_rdata),
    .dout     (dout),
    .dir      (dir),
    .mask     (mask),
    .status   (status),
    .any_edge (any_edge),
    .modes    (modes)
  );

  assign pad_out = dout;
  assign pad_oe  = dir;
  assign irq     = |(status & mask);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt))); // R6

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R10

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_LVL = 5'h08,
    A_MLO = 5'h0C, A_MHI = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18, A_ANY = 5'h1C;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_DATA, v); check("R1 data", v, 0);
    rd(A_DIR, v);  check("R1 dir", v, 0);
    rd(A_MLO, v);  check("R1 mode lo", v, 0);
    rd(A_MASK, v); check("R1 mask", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    check("R1 oe", pad_oe, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_output;
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_DATA, 32'hA5A5_1234);
    check("R2 oe", pad_oe, 32'h0000_FFFF);
    check("R2 out", pad_out & pad_oe, 32'h0000_1234);
  endtask

  task automatic t_input;
    logic [31:0] v;
    pad_in = 32'h5A5A_0000;
    cyc(1);
    rd(A_LVL, v); check("R4 one edge not yet", v, 0);
    cyc(1);
    rd(A_LVL, v); check("R4 level", v, 32'h5A5A_0000);
    rd(A_DATA, v); check("R3 data mix", v, 32'h5A5A_1234);
    wr(A_LVL, 32'hFFFF_FFFF);
    rd(A_LVL, v); check("R4 read-only", v, 32'h5A5A_0000);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    wr(A_MLO, 32'hAAAA_AAAA);
    wr(A_MHI, 32'hAAAA_ABAA);   // pin 20 falling
    cyc(2);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R5 quiet after config", v, 0);
    pad_in[3] = 1'b1;
    cyc(2);
    rd(A_STAT, v); check("R6 not before third edge", v, 0);
    cyc(1);
    rd(A_STAT, v); check("R5 R6 rising pin3", v, 32'h0000_0008);
    wr(A_STAT, 32'hFFFF_FFFF);
    pad_in[20] = 1'b0;
    cyc(3);
    rd(A_STAT, v); check("R5 falling pin20", v, 32'h0010_0000);
    wr(A_STAT, 32'hFFFF_FFFF);
    pad_in[20] = 1'b1;
    cyc(3);
    rd(A_STAT, v); check("R5 rise ignored in fall mode", v, 0);
  endtask

  task automatic t_anyedge;
    logic [31:0] v;
    wr(A_ANY, 32'h0000_0020);
    pad_in[5] = 1'b1;
    cyc(3);
    rd(A_STAT, v); check("R7 rise pin5", v, 32'h0000_0020);
    wr(A_STAT, 32'h0000_0020);
    pad_in[5] = 1'b0;
    pad_in[3] = 1'b0;
    cyc(3);
    rd(A_STAT, v); check("R7 fall pin5 only", v, 32'h0000_0020);
  endtask

  task automatic t_mask_w1c;
    logic [31:0] v;
    check("R10 masked irq low", {31'd0, irq}, 0);
    wr(A_MASK, 32'h0000_0020);
    check("R9 unmasked irq", {31'd0, irq}, 1);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, v); check("R8 write zero", v, 32'h0000_0020);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, v); check("R8 write one", v, 0);
    check("R10 irq after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(A_MLO, 32'hAAA9_AAAA);   // pin 8 high level
    pad_in[8] = 1'b1;
    cyc(3);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); check("R11 level re-set", v, 32'h0000_0100);
    pad_in[8] = 1'b0;
    cyc(3);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); check("R11 level gone", v, 0);
    pad_in[3] = 1'b1;
    cyc(2);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); check("R11 edge set wins", v, 32'h0000_0008);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); check("R11 later clear", v, 0);
  endtask

  task automatic run_all;
    t_reset;
    @(negedge clk) rst_n = 1'b1;
    cyc(1);
    t_output;
    t_input;
    t_edges;
    t_anyedge;
    t_mask_w1c;
    t_collide;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    cyc(2);
    fork
      run_all;
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule